// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer with Reset Pulse

This block is a watchdog timer reached through a small indexed register interface: an index selects one of three 8-bit registers, a write strobe stores the data, and the read data shows the selected register at once. The count register also controls the timer. A non-zero value loads the down-counter and starts it. A zero value stops a running timer. Reading the register gives the time left.

A free-running prescaler divides the clock into one-second ticks. Each non-zero load clears the prescaler, so the first second after a load is always full length. An optional minutes mode groups the seconds into units of `SEC_PER_MIN` seconds. When the count runs out, the block does three things. It drives the active-low `timeout_n` output low. It sets a sticky expiry flag in the status register. If the control register enables it, it also sends a low pulse of `PULSE_CYC` cycles on `kbd_rst_n`. Keyboard or mouse activity can stop a running timer, but only when software has enabled that source.

The counter state machine has three states. `CS_IDLE` moves to `CS_RUN` on a non-zero load. `CS_RUN` has four exits:
- back to `CS_RUN` on a reload;
- to `CS_IDLE` on a zero write;
- to `CS_IDLE` on an enabled stop source;
- to `CS_EXPIRED` when a unit tick arrives with a count of 1.

`CS_EXPIRED` moves to `CS_RUN` on a non-zero load. It ignores a zero write. The pulse state machine moves from `PS_IDLE` to `PS_LOW` on an expiry with the pulse enabled. It moves from `PS_LOW` back to `PS_IDLE` after `PULSE_CYC` cycles.

Top module: `wdsec_watchdog`

## Requirements
- R1: Writing a non-zero value V to index 0 loads the count with V and starts the timer. From the next cycle, index 0 reads V.
- R2: Writing 0 to index 0 while the timer runs stops it. The count reads 0, and no expiry follows.
- R3: A running count drops by one for every unit. Each load clears the prescaler, so the first decrement comes exactly `CLK_PER_SEC` cycles after the loading edge, even if the load falls in the middle of a second.
- R4: When the count reaches zero, `timeout_n` goes low in the same cycle. It stays low through any zero write and rises only on the next non-zero load or on reset.
- R5: Status bit 4 is set on expiry. Writing status with bit 4 at 0 clears it, and writing bit 4 at 1 leaves it unchanged. If a clear falls in the expiry cycle, the set wins.
- R6: With control bit 1 at 1, an expiry drives `kbd_rst_n` low for exactly `PULSE_CYC` cycles, starting at the expiry edge. With control bit 1 at 0, `kbd_rst_n` stays high.
- R7: With control bit 3 at 1, one count unit lasts `SEC_PER_MIN` seconds. With bit 3 at 0, a unit is one second.
- R8: A `kbd_activity` cycle stops a running timer only when control bit 2 and status bit 7 are both 1. A `mouse_activity` cycle stops it only when status bit 6 is 1. In all other cases the count is left unchanged.
- R9: A non-zero load in the same cycle as the final tick wins. The timer reloads and does not expire, the flag is not set, and no pulse is sent.
- R10: The register indices are: 0 for count, 1 for control, 2 for status. Control reads back bits 3:1 and shows 0 elsewhere. Status reads back bits 7, 6 and 4 and shows 0 elsewhere. Index 3 reads 0.
- R11: After reset, all registers read 0 and both outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the register at `cfg_idx` |
| kbd_activity | input | 1 | Keyboard activity, one cycle per event |
| mouse_activity | input | 1 | Mouse activity, one cycle per event |
| timeout_n | output | 1 | Low while the timer is expired |
| kbd_rst_n | output | 1 | Low pulse toward the keyboard-reset line |

## Verification
Two pairs of actions can fall on the same clock edge:
- the final unit tick and a software action on the registers;
- the expiry setting the status flag and a write that clears that flag.

The bench counts cycles from a known loading edge and places a reload exactly on the edge where the count would reach zero. It then checks that `timeout_n` stays high, that the count reads the new value and that no pulse appears. It also places a flag-clearing status write on the expiry edge and checks that the flag still reads as set while `timeout_n` is low.

// File: rtl/wdsec_pkg.sv
package wdsec_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] IDX_COUNT  = 2'd0;
    localparam logic [1:0] IDX_CTRL   = 2'd1;
    localparam logic [1:0] IDX_STATUS = 2'd2;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_RUN     = 2'd1,
        CS_EXPIRED = 2'd2
    } cnt_state_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_LOW  = 1'b1
    } pulse_state_t;
endpackage

// File: rtl/wdsec_prescale.sv
module wdsec_prescale #(
    parameter int CLK_PER_SEC = 32768,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic minutes,
    output logic unit_tick
);
    localparam int PRE_W = (CLK_PER_SEC > 2) ? $clog2(CLK_PER_SEC) : 1;
    localparam int MIN_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_SEC - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SEC_PER_MIN - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MIN_W-1:0] min_q;
    logic             sec_tick;

    assign sec_tick  = (pre_q == PRE_LAST);
    assign unit_tick = sec_tick && (!minutes || (min_q == MIN_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            min_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            min_q <= '0;
        end else begin
            pre_q <= sec_tick ? '0 : pre_q + 1'b1;
            if (sec_tick)
                min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        end
    end

    // R3: unit ticks never come back to back
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unit_tick |=> !unit_tick);
endmodule

// File: rtl/wdsec_counter.sv
module wdsec_counter
    import wdsec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             unit_tick,
    input  logic             stop_req,
    output logic [CNT_W-1:0] count,
    output logic             restart,
    output logic             expire_evt,
    output logic             timeout_n
);
    cnt_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             load_zero;

    assign restart   = load_we && (load_val != '0);
    assign load_zero = load_we && (load_val == '0);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            CS_IDLE: begin
                if (restart) begin
                    state_d = CS_RUN;
                    count_d = load_val;
                end
            end
            CS_RUN: begin
                if (restart) begin
                    count_d = load_val;
                end else if (load_zero || stop_req) begin
                    state_d = CS_IDLE;
                    count_d = '0;
                end else if (unit_tick) begin
                    if (count_q == CNT_W'(1)) begin
                        state_d = CS_EXPIRED;
                        count_d = '0;
                    end else begin
                        count_d = count_q - 1'b1;
                    end
                end
            end
            CS_EXPIRED: begin
                if (restart) begin
                    state_d = CS_RUN;
                    count_d = load_val;
                end
            end
            default: begin
                state_d = CS_IDLE;
                count_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        count      = count_q;
        timeout_n  = (state_q != CS_EXPIRED);
        expire_evt = (state_q == CS_RUN) && (state_d == CS_EXPIRED);
    end

    // R1: a running timer never holds a zero count
    p_run_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN) |-> (count_q != '0));
    // R2: a zero write stops a running timer
    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && load_zero) |=> (state_q == CS_IDLE && count_q == '0));
    // R3: one step down per unit tick
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && !load_we && !stop_req && unit_tick && count_q > CNT_W'(1))
        |=> (count_q == $past(count_q) - 1'b1));
    // R4: expiry is held until a non-zero load
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_EXPIRED && !restart) |=> (state_q == CS_EXPIRED));
    // R9: a non-zero load always wins
    p_reload_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q == CS_RUN && count_q == $past(load_val)));
endmodule

// File: rtl/wdsec_pulse.sv
module wdsec_pulse
    import wdsec_pkg::*;
#(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LEN_M1 = CW'(PULSE_CYC - 1);

    pulse_state_t  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                if (fire) begin
                    state_d = PS_LOW;
                    cnt_d   = LEN_M1;
                end
            end
            PS_LOW: begin
                if (fire) begin
                    cnt_d = LEN_M1;
                end else if (cnt_q == '0) begin
                    state_d = PS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb pulse_n = (state_q != PS_LOW);

    // R6: pulse counter stays inside the programmed length
    p_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LOW) |-> (cnt_q <= LEN_M1));
    // R6: pulse ends only after the counter has run out
    p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_n) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/wdsec_watchdog.sv
module wdsec_watchdog
    import wdsec_pkg::*;
#(
    parameter int CLK_PER_SEC = 32768,
    parameter int SEC_PER_MIN = 60,
    parameter int PULSE_CYC   = 16,
    parameter int CNT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              kbd_activity,
    input  logic              mouse_activity,
    output logic              timeout_n,
    output logic              kbd_rst_n
);
    // control: [2]=minutes mode, [1]=keyboard stop allow, [0]=pulse enable
    logic [2:0]       ctrl_q;
    logic             stat_kbd_q, stat_mouse_q, stat_flag_q;
    logic [CNT_W-1:0] count;
    logic             unit_tick, restart, expire_evt, stop_req;
    logic             wr_count, wr_ctrl, wr_stat;

    assign wr_count = cfg_we && (cfg_idx == IDX_COUNT);
    assign wr_ctrl  = cfg_we && (cfg_idx == IDX_CTRL);
    assign wr_stat  = cfg_we && (cfg_idx == IDX_STATUS);
    assign stop_req = (kbd_activity && ctrl_q[1] && stat_kbd_q) ||
                      (mouse_activity && stat_mouse_q);

    wdsec_prescale #(.CLK_PER_SEC(CLK_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .minutes(ctrl_q[2]), .unit_tick(unit_tick)
    );

    wdsec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_we(wr_count),
        .load_val(cfg_wdata[CNT_W-1:0]), .unit_tick(unit_tick),
        .stop_req(stop_req), .count(count), .restart(restart),
        .expire_evt(expire_evt), .timeout_n(timeout_n)
    );

    wdsec_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire_evt && ctrl_q[0]),
        .pulse_n(kbd_rst_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            stat_kbd_q   <= 1'b0;
            stat_mouse_q <= 1'b0;
            stat_flag_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= cfg_wdata[3:1];
            if (wr_stat) begin
                stat_kbd_q   <= cfg_wdata[7];
                stat_mouse_q <= cfg_wdata[6];
            end
            if (expire_evt)
                stat_flag_q <= 1'b1;
            else if (wr_stat && !cfg_wdata[4])
                stat_flag_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_idx)
            IDX_COUNT:  cfg_rdata = DATA_W'(count);
            IDX_CTRL:   cfg_rdata = {4'b0000, ctrl_q, 1'b0};
            IDX_STATUS: cfg_rdata = {stat_kbd_q, stat_mouse_q, 1'b0, stat_flag_q, 4'b0000};
            default:    cfg_rdata = '0;
        endcase
    end

    // R5: the flag is set whenever the timeout output falls
    p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_n) |-> stat_flag_q);
    // R5: the flag only clears through a status write with bit 4 low
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flag_q && !(wr_stat && !cfg_wdata[4])) |=> stat_flag_q);
    // R6: a pulse needs the enable bit
    p_pulse_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kbd_rst_n) |-> $past(ctrl_q[0]));
endmodule

// File: tb/test_wdsec_watchdog.sv
module test_wdsec_watchdog;
    localparam int CPS = 8;
    localparam int SPM = 4;
    localparam int PLS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       kbd_activity = 1'b0;
    logic       mouse_activity = 1'b0;
    logic       timeout_n, kbd_rst_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wdsec_watchdog #(.CLK_PER_SEC(CPS), .SEC_PER_MIN(SPM), .PULSE_CYC(PLS), .CNT_W(8))
    i_wdsec_watchdog (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .kbd_activity(kbd_activity), .mouse_activity(mouse_activity),
        .timeout_n(timeout_n), .kbd_rst_n(kbd_rst_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; write is taken at the next posedge
    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output int v);
        cfg_idx = idx;
        #1 v = int'(cfg_rdata);
    endtask

    task automatic pulse_kbd();
        kbd_activity = 1'b1; @(negedge clk); kbd_activity = 1'b0;
    endtask

    task automatic pulse_mouse();
        mouse_activity = 1'b1; @(negedge clk); mouse_activity = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v); check("R11 reg after reset", v, 0);
        end
        check("R11 timeout_n after reset", int'(timeout_n), 1);
        check("R11 kbd_rst_n after reset", int'(kbd_rst_n), 1);
    endtask

    task automatic t_regmap();
        int v;
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R10 control readback", v, 8'h0E);
        wr(2'd2, 8'hFF); rd(2'd2, v); check("R10 R5 status readback, bit4 write-1 no effect", v, 8'hC0);
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R10 index 3 reads 0", v, 0);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        rd(2'd1, v); check("R10 control cleared", v, 0);
    endtask

    task automatic t_countdown();
        int v;
        wr(2'd0, 8'd3); rd(2'd0, v); check("R1 load readback", v, 3);
        wait_n(3);
        wr(2'd0, 8'd3);             // reload mid-second
        wait_n(CPS - 1); rd(2'd0, v); check("R3 first second full length", v, 3);
        wait_n(1); rd(2'd0, v); check("R3 first decrement", v, 2);
        wait_n(CPS); rd(2'd0, v); check("R3 second decrement", v, 1);
        wr(2'd0, 8'd0); rd(2'd0, v); check("R2 stop reads 0", v, 0);
    endtask

    task automatic t_expiry_pulse();
        int v;
        wr(2'd1, 8'h02);
        wr(2'd0, 8'd2);
        wait_n(2 * CPS - 1);
        check("R4 not yet expired", int'(timeout_n), 1);
        rd(2'd0, v); check("R3 count one before end", v, 1);
        wait_n(1);
        check("R4 timeout_n low at expiry", int'(timeout_n), 0);
        check("R6 pulse starts at expiry", int'(kbd_rst_n), 0);
        rd(2'd2, v); check("R5 flag set", v, 8'h10);
        wait_n(PLS - 1); check("R6 pulse still low at last cycle", int'(kbd_rst_n), 0);
        wait_n(1); check("R6 pulse ended", int'(kbd_rst_n), 1);
        wr(2'd0, 8'd0); check("R4 zero write keeps expiry", int'(timeout_n), 0);
        wr(2'd2, 8'h10); rd(2'd2, v); check("R5 bit4 write 1 keeps flag", v, 8'h10);
        wr(2'd2, 8'h00); rd(2'd2, v); check("R5 flag cleared", v, 0);
        wr(2'd0, 8'd5); check("R4 non-zero load releases", int'(timeout_n), 1);
        wr(2'd0, 8'd0);
    endtask

    task automatic t_no_pulse();
        int seen = 1;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd1);
        wait_n(CPS);
        check("R4 expiry without pulse", int'(timeout_n), 0);
        for (int i = 0; i < PLS + 2; i++) begin
            if (kbd_rst_n !== 1'b1) seen = 0;
            wait_n(1);
        end
        check("R6 no pulse when disabled", seen, 1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_stop();
        int v;
        wr(2'd0, 8'd2); check("R1 start from expired", int'(timeout_n), 1);
        wait_n(CPS);
        wr(2'd0, 8'd0); rd(2'd0, v); check("R2 count 0 after stop", v, 0);
        wait_n(3 * CPS);
        check("R2 no expiry after stop", int'(timeout_n), 1);
        rd(2'd2, v); check("R2 flag stays clear", v, 0);
    endtask

    task automatic t_minutes();
        int v;
        wr(2'd1, 8'h08);
        wr(2'd0, 8'd1);
        wait_n(SPM * CPS - 1);
        check("R7 still running before minute ends", int'(timeout_n), 1);
        rd(2'd0, v); check("R7 count held within minute", v, 1);
        wait_n(1);
        check("R7 expiry after one minute", int'(timeout_n), 0);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_stop_sources();
        int v;
        wr(2'd2, 8'h80); wr(2'd1, 8'h00); wr(2'd0, 8'd5);
        pulse_kbd(); rd(2'd0, v); check("R8 keyboard ignored, control bit2=0", v, 5);
        wr(2'd1, 8'h04);
        pulse_kbd(); rd(2'd0, v); check("R8 keyboard stops", v, 0);
        wr(2'd0, 8'd5); wr(2'd2, 8'h40);
        pulse_kbd(); rd(2'd0, v); check("R8 keyboard ignored, status bit7=0", v, 5);
        pulse_mouse(); rd(2'd0, v); check("R8 mouse stops", v, 0);
        wr(2'd2, 8'h00); wr(2'd0, 8'd5);
        pulse_mouse(); rd(2'd0, v); check("R8 mouse ignored, status bit6=0", v, 5);
        wr(2'd0, 8'd0); wr(2'd1, 8'h00);
    endtask

    task automatic t_coincide();
        int v;
        wr(2'd1, 8'h02);
        wr(2'd0, 8'd2);
        wait_n(2 * CPS - 1);
        wr(2'd0, 8'd4);            // taken on the final-tick edge
        check("R9 reload beats expiry", int'(timeout_n), 1);
        check("R9 no pulse", int'(kbd_rst_n), 1);
        rd(2'd0, v); check("R9 reloaded value", v, 4);
        rd(2'd2, v); check("R9 flag not set", v, 0);
        wait_n(CPS - 1); rd(2'd0, v); check("R9 R3 full second after reload", v, 4);
        wait_n(1); rd(2'd0, v); check("R9 R3 decrement after reload", v, 3);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd1);
        wait_n(CPS - 1);
        wr(2'd2, 8'h00);           // clear on the expiry edge
        check("R5 expiry in clear cycle", int'(timeout_n), 0);
        rd(2'd2, v); check("R5 set wins over clear", v, 8'h10);
        wr(2'd2, 8'h00); rd(2'd2, v); check("R5 later clear works", v, 0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_regmap();
        t_countdown();
        t_expiry_pulse();
        t_no_pulse();
        t_stop();
        t_minutes();
        t_stop_sources();
        t_coincide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule